// File: doc/BRIEF.md
# Amplifier Control Register Slave

This block is the control port of a variable-gain amplifier. A host talks to it over a four-wire serial link in the common SPI mode 0 form: a clock, an active-low select, a data input and a data output with an enable. Each access is one frame of exactly sixteen serial clocks. The first byte says whether the access reads or writes and which register it targets. The second byte carries either the value to write or the value being read back.

The map has four byte-wide locations. Two of them hold fixed identification codes and cannot be written. The other two hold the amplifier's settings: a shutdown control and a gain-reduction code. The block drives the decoded shutdown flag and the gain-reduction code straight out to the analog section. The gain is 26 dB minus 0.25 dB per step of the code.

All link signals are brought into the block's own clock domain through two-flop synchronizers, and the logic acts on the edges it detects there. For this to work, the system clock must run several times faster than the serial clock.

Top module: `amp_ctrl_spi_regs`

## Requirements
- R1: After reset, location 0 reads 0x01, location 1 reads 0x20, location 2 reads 0x00 and location 3 reads 0x50. The outputs are `pwr_down` = 0 and `atten` = 80.
- R2: A frame starts when `cs_n` falls and ends when it rises. Data on `sdi` is taken on rising `sclk`, MSB first. Command bit 7 is the access flag (1 = read, 0 = write). Bits 6 to 4 are ignored, and bits 3 to 0 give the location.
- R3: On a read, `sdo` carries the addressed byte MSB first during clocks 9 to 16, changing after falling `sclk` edges. `sdo_oe` is 0 during the command byte, throughout write frames, and while `cs_n` is high.
- R4: Writes to locations 0 and 1 are ignored, and those locations keep their fixed values.
- R5: Writes to locations 4 to 15 change nothing. A read of locations 4 to 15 returns 0x00.
- R6: Location 2 stores only data bits 1:0, and its other bits read as 0. `pwr_down` is 1 exactly when the stored field is binary 11.
- R7: Location 3 stores data bits 6:0, and bit 7 is ignored and reads as 0. A value above 80 is stored as 80. `atten` always equals the stored value.
- R8: If `cs_n` rises before the 16th rising `sclk`, no location is updated. The next frame is decoded from its own first bit.
- R9: A write takes effect on the 16th rising `sclk` of its frame. Any further clocks before `cs_n` rises are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, several times faster than `sclk` |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low frame select |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial read data to the host |
| sdo_oe | output | 1 | Drive enable for `sdo`; when low, the pad is high-impedance |
| pwr_down | output | 1 | Amplifier shutdown, high when the shutdown field is binary 11 |
| atten | output | 7 | Gain-reduction code, 0 to 80, in quarter-dB steps |

## Verification
The assertions assume that `sclk`, `cs_n` and `sdi` each stay steady for more than three system clocks between changes. Under that assumption every serial edge is seen exactly once after synchronization. They also assume that `cs_n` changes only while `sclk` is low. The bench holds each serial half-period for six system clocks, and it moves `cs_n` and `sdi` only during the low phase, well away from rising `sclk`. The host samples `sdo` at the end of the low phase, which is long after the slave has updated the pin.

// File: rtl/amp_ctrl_spi_regs.sv
module amp_ctrl_spi_regs #(
  parameter logic [7:0] REV_CODE  = 8'h01,
  parameter logic [7:0] PART_CODE = 8'h20,
  parameter logic [1:0] PD_INIT   = 2'b00,
  parameter logic [6:0] ATT_INIT  = 7'd80,
  parameter logic [6:0] ATT_LIMIT = 7'd80
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclk,
  input  logic       cs_n,
  input  logic       sdi,
  output logic       sdo,
  output logic       sdo_oe,
  output logic       pwr_down,
  output logic [6:0] atten
);

  logic [2:0] sclk_p;
  logic [1:0] cs_p;
  logic [1:0] sdi_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_p <= '0;
      cs_p   <= 2'b11;
      sdi_p  <= '0;
    end else begin
      sclk_p <= {sclk_p[1:0], sclk};
      cs_p   <= {cs_p[0], cs_n};
      sdi_p  <= {sdi_p[0], sdi};
    end
  end

  wire s_rise = sclk_p[1] & ~sclk_p[2];
  wire s_fall = ~sclk_p[1] & sclk_p[2];
  wire idle   = cs_p[1];
  wire din    = sdi_p[1];

  logic [4:0] cnt;
  logic [6:0] cmd_sr;
  logic [6:0] dat_sr;
  logic       rd_flag;
  logic [3:0] addr;
  logic [7:0] rd_byte;
  logic [1:0] pd_q;

  wire [3:0] addr_nx = {cmd_sr[2:0], din};
  wire [7:0] wbyte   = {dat_sr, din};
  wire       cmd_end = s_rise && !idle && cnt == 5'd7;
  wire       do_wr   = s_rise && !idle && cnt == 5'd15 && !rd_flag;
  wire [6:0] att_in  = (wbyte[6:0] > ATT_LIMIT) ? ATT_LIMIT : wbyte[6:0];

  logic [7:0] rd_mux;
  always_comb begin
    case (addr_nx)
      4'd0:    rd_mux = REV_CODE;
      4'd1:    rd_mux = PART_CODE;
      4'd2:    rd_mux = {6'b0, pd_q};
      4'd3:    rd_mux = {1'b0, atten};
      default: rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      cmd_sr  <= '0;
      dat_sr  <= '0;
      rd_flag <= 1'b0;
      addr    <= '0;
      rd_byte <= '0;
    end else if (idle) begin
      cnt     <= '0;
      rd_flag <= 1'b0;
    end else if (s_rise) begin
      if (cnt != 5'd16) cnt <= cnt + 5'd1;
      if (cnt < 5'd7) cmd_sr <= {cmd_sr[5:0], din};
      if (cnt >= 5'd8 && cnt < 5'd15) dat_sr <= {dat_sr[5:0], din};
      if (cmd_end) begin
        rd_flag <= cmd_sr[6];
        addr    <= addr_nx;
        rd_byte <= rd_mux;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pd_q  <= PD_INIT;
      atten <= ATT_INIT;
    end else if (do_wr) begin
      case (addr)
        4'd2:    pd_q  <= wbyte[1:0];
        4'd3:    atten <= att_in;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sdo    <= 1'b0;
      sdo_oe <= 1'b0;
    end else if (idle) begin
      sdo_oe <= 1'b0;
    end else if (s_fall) begin
      if (rd_flag && cnt >= 5'd8 && cnt <= 5'd15) begin
        sdo    <= rd_byte[~cnt[2:0]];
        sdo_oe <= 1'b1;
      end else begin
        sdo_oe <= 1'b0;
      end
    end
  end

  assign pwr_down = &pd_q;

  // R7
  atten_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    atten <= ATT_LIMIT);

  // R3
  sdo_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle |=> !sdo_oe);

  // R3
  sdo_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !s_fall |=> $stable(sdo));

  // R8
  no_stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !do_wr |=> ($stable(atten) && $stable(pwr_down)));

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= 5'd16);

  // R3
  oe_read_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_oe |-> rd_flag);

endmodule

// File: tb/amp_ctrl_spi_regs_test.sv
module amp_ctrl_spi_regs_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0;
  logic cs_n = 1'b1;
  logic sdi = 1'b0;
  logic sdo, sdo_oe, pwr_down;
  logic [6:0] atten;

  amp_ctrl_spi_regs uut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .pwr_down(pwr_down), .atten(atten)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int fails = 0;
  int cycle = 0;
  int settle_until = 1 << 30;
  bit done = 0;

  int m_pd = 0;
  int m_att = 80;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycle++;
    if (rst_n && cycle > settle_until) begin
      chk(pwr_down == (m_pd == 3), "R6 pwr_down", pwr_down, m_pd == 3);
      chk(atten == m_att[6:0], "R7 atten", atten, m_att);
    end
  end

  function automatic int model_read(input int a);
    case (a)
      0: return 8'h01;
      1: return 8'h20;
      2: return m_pd;
      3: return m_att;
      default: return 0;
    endcase
  endfunction

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(input bit rw, input int a, input int data, input int nclk,
                       output int rd);
    logic [7:0] cmd;
    cmd = {rw, 3'b000, 4'(a)};
    rd = 0;
    cs_n = 1'b0;
    wait_clk(6);
    for (int i = 0; i < nclk; i++) begin
      sdi = (i < 8) ? cmd[7 - i] : ((i < 16) ? data[15 - i] : 1'b0);
      wait_clk(6);
      if (i < 8)
        chk(sdo_oe == 1'b0, "R3 oe low in command", sdo_oe, 0);
      else if (i < 16) begin
        chk(sdo_oe == rw, "R3 oe in data phase", sdo_oe, rw);
        if (rw) rd[15 - i] = sdo;
      end
      sclk = 1'b1;
      if (i == 15 && !rw) begin
        if (a == 2) m_pd = data & 3;
        if (a == 3) m_att = ((data & 8'h7f) > 80) ? 80 : (data & 8'h7f);
        settle_until = cycle + 8;
      end
      wait_clk(6);
      sclk = 1'b0;
    end
    wait_clk(6);
    cs_n = 1'b1;
    wait_clk(6);
    chk(sdo_oe == 1'b0, "R3 oe low when idle", sdo_oe, 0);
    wait_clk(4);
  endtask

  task automatic wr(input int a, input int data);
    int dummy;
    frame(1'b0, a, data, 16, dummy);
  endtask

  task automatic rd_chk(input int a, input string req);
    int v;
    frame(1'b1, a, 0, 16, v);
    chk(v == model_read(a), req, v, model_read(a));
  endtask

  task automatic summary;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(3);
    chk(pwr_down == 1'b0, "R1 reset pwr_down", pwr_down, 0);
    chk(atten == 7'd80, "R1 reset atten", atten, 80);
    settle_until = cycle;
    for (int a = 0; a < 4; a++) rd_chk(a, "R1 reset readback");

    wr(2, 8'h03);
    chk(pwr_down == 1'b1, "R6 off code", pwr_down, 1);
    rd_chk(2, "R6 readback 11");
    wr(2, 8'hFD);
    rd_chk(2, "R6 reserved bits zero");
    chk(pwr_down == 1'b0, "R6 01 keeps on", pwr_down, 0);
    wr(2, 8'h00);
    rd_chk(2, "R6 cleared");

    wr(3, 8'h20);
    rd_chk(3, "R7 plain write");
    wr(3, 8'h7F);
    chk(atten == 7'd80, "R7 clamp 127", atten, 80);
    wr(3, 8'hC5);
    rd_chk(3, "R7 bit7 ignored");
    wr(3, 81);
    chk(atten == 7'd80, "R7 clamp 81", atten, 80);
    wr(3, 80);
    rd_chk(3, "R7 exact 80");
    wr(3, 0);
    rd_chk(3, "R7 zero");

    wr(0, 8'hAA);
    wr(1, 8'h55);
    rd_chk(0, "R4 revision kept");
    rd_chk(1, "R4 part kept");

    wr(5, 8'h33);
    wr(15, 8'h03);
    rd_chk(2, "R5 write 5/15 ignored pd");
    rd_chk(3, "R5 write 5/15 ignored att");
    rd_chk(9, "R5 unmapped read");
    rd_chk(4, "R5 unmapped read 4");

    begin
      int d;
      frame(1'b0, 3, 8'h11, 12, d);
      frame(1'b0, 2, 8'h03, 15, d);
    end
    chk(atten == 7'd0, "R8 aborted att", atten, 0);
    chk(pwr_down == 1'b0, "R8 aborted pd", pwr_down, 0);
    wr(3, 8'h12);
    rd_chk(3, "R8 fresh frame after abort");

    begin
      int d;
      frame(1'b0, 3, 8'h2A, 20, d);
    end
    rd_chk(3, "R9 extra clocks ignored");
    begin
      int v;
      frame(1'b1, 2, 0, 16, v);
      chk(v == 0 && pwr_down == 1'b0, "R2 read leaves pd", v, 0);
    end
    summary();
  end

  initial begin
    wait (cycle > 100000);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cycle, 100000);
    summary();
  end
endmodule